// File: doc/BRIEF.md
# Single-Wire Register Readback Transmitter

This block drives the shared data line of a half-duplex, single-wire calibration port. The receive path decodes a 4-bit command and presents it together with a 4-bit register pointer, a 4-bit analog source select and a 4-bit window timing field. On a read command, the block latches the pointer onto the register-file mux select. It leaves the line released for one full byte time so that the host can turn its driver around. It then transmits the selected byte with start and stop framing, one bit per bit-period tick.

On an analog-output command, the block opens a timed window. During the window a separate output pin is enabled with the latched source select, and the data line stays released. A command that arrives while either sequence is in progress is dropped. Bit-rate recovery is outside this block: a one-cycle tick marks each bit period.

Top module: `rdbk_tx`

## Requirements
- R1: During and immediately after reset, dio_oe_o, ana_en_o and busy_o are low and dio_do_o is high.
- R2: When the block is idle and cmd_valid_i is high with cmd_i = 4'h9 (read), reg_sel_o takes ptr_i and busy_o is high on the next cycle.
- R3: After a read command, dio_oe_o stays low for 10 bit-period ticks. The first tick that counts is the first one seen after the accept cycle.
- R4: While dio_oe_o is high, the block sends 10 bit periods, each ending on a tick. The order is: start bit low, then the 8 bits of reg_byte_i least significant bit first, then the stop bit high. reg_byte_i is captured on the tenth turnaround tick.
- R5: On the tick that ends the stop bit, dio_oe_o and busy_o fall together on the next cycle, and the block accepts commands again.
- R6: When the block is idle and cmd_valid_i is high with cmd_i = 4'hA (analog), ana_sel_o takes src_sel_i and ana_en_o and busy_o rise on the next cycle. dio_oe_o stays low for the whole window.
- R7: The analog window lasts 2^(win_time_i+1) ticks. ana_en_o falls on the cycle after the last of those ticks.
- R8: A command presented while busy_o is high is ignored. This holds in the cycle of the final tick, and it leaves reg_sel_o, ana_sel_o and all timing unchanged.
- R9: When the block is idle, a valid command with any code other than 4'h9 or 4'hA leaves busy_o, dio_oe_o and ana_en_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse per bit period |
| cmd_valid_i | input | 1 | Command strobe from the decoder |
| cmd_i | input | 4 | Command code |
| ptr_i | input | 4 | Register pointer for a read |
| src_sel_i | input | 4 | Analog source select |
| win_time_i | input | 4 | Analog window timing field |
| reg_byte_i | input | 8 | Byte from the register-file mux |
| reg_sel_o | output | 4 | Mux select for the register file |
| dio_oe_o | output | 1 | Data pad output enable |
| dio_do_o | output | 1 | Data pad output value |
| ana_en_o | output | 1 | Analog output pin enable |
| ana_sel_o | output | 4 | Latched analog source select |
| busy_o | output | 1 | Sequence in progress |

## Verification
Two events can fall in the same cycle. The first is a command strobe and a bit-period tick: a tick that coincides with acceptance must not count toward the turnaround. The second is a new command and the tick that ends the stop bit: that command must still be dropped. The bench reaches both cases by watching its own model for the exact cycle and then raising the strobe there. A per-cycle reference model judges the result on every clock, and explicit checks afterwards confirm that busy_o is low and reg_sel_o is unchanged.

// File: rtl/rdbk_pkg.sv
package rdbk_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_TURN, ST_SEND, ST_WIN} rdbk_st_e;
  localparam int FRAME_BITS = 10;
endpackage

// File: rtl/rdbk_ctrl.sv
module rdbk_ctrl
  import rdbk_pkg::*;
#(
  parameter int CMD_W  = 4,
  parameter int PTR_W  = 4,
  parameter int TIME_W = 4,
  parameter int CNT_W  = 16,
  parameter logic [CMD_W-1:0] CMD_RD = 4'h9,
  parameter logic [CMD_W-1:0] CMD_AN = 4'hA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cmd_valid_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [PTR_W-1:0]  src_sel_i,
  input  logic [TIME_W-1:0] win_time_i,
  output rdbk_st_e          st_o,
  output logic              load_o,
  output logic [PTR_W-1:0]  sel_o,
  output logic [PTR_W-1:0]  asel_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

  rdbk_st_e         st_q;
  logic [CNT_W-1:0] cnt_q, lim_q;
  logic [PTR_W-1:0] sel_q, asel_q;

  assign load_o = (st_q == ST_TURN) && tick_i && (cnt_q == LAST_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      lim_q  <= '0;
      sel_q  <= '0;
      asel_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (cmd_valid_i) begin
          cnt_q <= '0;
          if (cmd_i == CMD_RD) begin
            st_q  <= ST_TURN;
            sel_q <= ptr_i;
          end else if (cmd_i == CMD_AN) begin
            st_q   <= ST_WIN;
            asel_q <= src_sel_i;
            // window of 2^(t+1) ticks: limit is that count minus one
            lim_q  <= {CNT_W{1'b1}} >> (CNT_W - 1 - int'(win_time_i));
          end
        end
        ST_TURN, ST_SEND: if (tick_i) begin
          if (cnt_q == LAST_BIT) begin
            cnt_q <= '0;
            st_q  <= (st_q == ST_TURN) ? ST_SEND : ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WIN: if (tick_i) begin
          if (cnt_q == lim_q) st_q <= ST_IDLE;
          else                cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o   = st_q;
  assign sel_o  = sel_q;
  assign asel_o = asel_q;

  // R2
  rd_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && cmd_valid_i && cmd_i == CMD_RD)
      |=> (st_q == ST_TURN && sel_q == $past(ptr_i)));
  // R8
  hold_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> ($stable(sel_q) && $stable(asel_q)));
  // R7
  win_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WIN) |-> (cnt_q <= lim_q));
  // R3
  turn_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TURN) |-> (cnt_q <= LAST_BIT));
endmodule

// File: rtl/rdbk_shift.sv
module rdbk_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              bit_o
);
  logic [DATA_W+1:0] sr_q;

  // frame sits LSB-first: start(0), data, stop(1); refill with idle ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '1;
    else if (load_i)  sr_q <= {1'b1, data_i, 1'b0};
    else if (shift_i) sr_q <= {1'b1, sr_q[DATA_W+1:1]};
  end

  assign bit_o = sr_q[0];

  // R4
  load_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (bit_o == 1'b0));
endmodule

// File: rtl/rdbk_tx.sv
module rdbk_tx
  import rdbk_pkg::*;
#(
  parameter int CMD_W  = 4,
  parameter int PTR_W  = 4,
  parameter int TIME_W = 4,
  parameter int DATA_W = 8,
  parameter logic [CMD_W-1:0] CMD_RD = 4'h9,
  parameter logic [CMD_W-1:0] CMD_AN = 4'hA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cmd_valid_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic [PTR_W-1:0]  src_sel_i,
  input  logic [TIME_W-1:0] win_time_i,
  input  logic [DATA_W-1:0] reg_byte_i,
  output logic [PTR_W-1:0]  reg_sel_o,
  output logic              dio_oe_o,
  output logic              dio_do_o,
  output logic              ana_en_o,
  output logic [PTR_W-1:0]  ana_sel_o,
  output logic              busy_o
);
  localparam int WIN_MAX_LOG = 1 << TIME_W;
  localparam int CNT_W = (WIN_MAX_LOG > 4) ? WIN_MAX_LOG : 4;

  rdbk_st_e st;
  logic     load, tx_bit;

  rdbk_ctrl #(
    .CMD_W(CMD_W), .PTR_W(PTR_W), .TIME_W(TIME_W), .CNT_W(CNT_W),
    .CMD_RD(CMD_RD), .CMD_AN(CMD_AN)
  ) i_ctrl (
    .clk_i, .rst_ni, .tick_i, .cmd_valid_i, .cmd_i, .ptr_i,
    .src_sel_i, .win_time_i,
    .st_o(st), .load_o(load), .sel_o(reg_sel_o), .asel_o(ana_sel_o)
  );

  rdbk_shift #(.DATA_W(DATA_W)) i_shift (
    .clk_i, .rst_ni,
    .load_i(load),
    .shift_i(tick_i && st == ST_SEND),
    .data_i(reg_byte_i),
    .bit_o(tx_bit)
  );

  assign dio_oe_o = (st == ST_SEND);
  assign dio_do_o = tx_bit | ~dio_oe_o;
  assign ana_en_o = (st == ST_WIN);
  assign busy_o   = (st != ST_IDLE);

  // R4
  start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dio_oe_o) |-> !dio_do_o);
  // R5
  stop_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dio_oe_o) |-> ($past(dio_do_o) && !busy_o));
  // R3
  turn_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dio_oe_o) |-> ($past(st) == ST_TURN));
  // R6
  win_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ana_en_o |-> !dio_oe_o);
endmodule

// File: tb/test_rdbk_tx.sv
module test_rdbk_tx;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_i = 1'b0, cmd_valid = 1'b0;
  logic [3:0] cmd = '0, ptr = '0, src = '0, wtime = '0;
  logic [7:0] reg_byte;
  logic [3:0] reg_sel, ana_sel;
  logic dio_oe, dio_do, ana_en, busy;

  logic [7:0] regs [16];
  int n_vec = 0, n_bad = 0, cyc = 0, tick_div = 3, tick_ph = 0;

  // reference model state
  int m_mode = 0, m_cnt = 0, m_idx = 0, m_lim = 0;
  logic [3:0] m_sel = '0, m_asel = '0;
  logic [9:0] m_frame = '1;

  always #(CLK_PERIOD/2) clk = ~clk;

  initial for (int i = 0; i < 16; i++) regs[i] = 8'(i * 37 + 11);
  assign reg_byte = regs[reg_sel];

  rdbk_tx i_rdbk_tx (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick_i), .cmd_valid_i(cmd_valid),
    .cmd_i(cmd), .ptr_i(ptr), .src_sel_i(src), .win_time_i(wtime),
    .reg_byte_i(reg_byte), .reg_sel_o(reg_sel), .dio_oe_o(dio_oe),
    .dio_do_o(dio_do), .ana_en_o(ana_en), .ana_sel_o(ana_sel), .busy_o(busy)
  );

  always @(negedge clk) begin
    tick_ph <= (tick_ph + 1 >= tick_div) ? 0 : tick_ph + 1;
    tick_i  <= (tick_ph + 1 >= tick_div);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode <= 0; m_cnt <= 0; m_idx <= 0; m_sel <= '0; m_asel <= '0;
    end else begin
      case (m_mode)
        0: if (cmd_valid) begin
          if (cmd == 4'h9) begin m_mode <= 1; m_cnt <= 0; m_sel <= ptr; end
          else if (cmd == 4'hA) begin
            m_mode <= 3; m_cnt <= 0; m_asel <= src;
            m_lim <= (1 << (int'(wtime) + 1)) - 1;
          end
        end
        1: if (tick_i) begin
          if (m_cnt == 9) begin
            m_mode <= 2; m_idx <= 0; m_frame <= {1'b1, regs[m_sel], 1'b0};
          end else m_cnt <= m_cnt + 1;
        end
        2: if (tick_i) begin
          if (m_idx == 9) m_mode <= 0; else m_idx <= m_idx + 1;
        end
        3: if (tick_i) begin
          if (m_cnt == m_lim) m_mode <= 0; else m_cnt <= m_cnt + 1;
        end
        default: m_mode <= 0;
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(busy == (m_mode != 0), "R5 busy", busy, m_mode != 0);
      chk(dio_oe == (m_mode == 2), "R3/R4 oe", dio_oe, m_mode == 2);
      chk(dio_do == ((m_mode == 2) ? m_frame[m_idx] : 1'b1), "R4 data", dio_do,
          (m_mode == 2) ? m_frame[m_idx] : 1'b1);
      chk(ana_en == (m_mode == 3), "R7 window", ana_en, m_mode == 3);
      chk(reg_sel == m_sel, "R2/R8 reg_sel", reg_sel, m_sel);
      chk(ana_sel == m_asel, "R6/R8 ana_sel", ana_sel, m_asel);
    end
    if (cyc > 190000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <190000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic issue(input logic [3:0] c, input logic [3:0] p,
                       input logic [3:0] s, input logic [3:0] t);
    cmd_valid = 1'b1; cmd = c; ptr = p; src = s; wtime = t;
    @(negedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do begin @(negedge clk); #1; end while (m_mode != 0);
    repeat (3) @(negedge clk);
    #1;
  endtask

  initial begin
    #1;
    repeat (2) @(negedge clk);
    // R1
    chk(!dio_oe && !ana_en && !busy && dio_do, "R1 reset", {dio_oe, ana_en, busy, dio_do}, 1);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!dio_oe && !ana_en && !busy && dio_do, "R1 after reset", {dio_oe, ana_en, busy, dio_do}, 1);

    // R2 R3 R4 read at slow tick
    issue(4'h9, 4'd5, 4'd0, 4'd0);
    chk(busy && reg_sel == 4'd5, "R2 accept", reg_sel, 5);
    // R8 command while busy
    issue(4'hA, 4'd7, 4'd7, 4'd2);
    issue(4'h9, 4'd2, 4'd0, 4'd0);
    chk(reg_sel == 4'd5 && !ana_en, "R8 busy ignore", reg_sel, 5);
    wait_idle();
    chk(!busy && !dio_oe, "R5 idle", busy, 0);

    // R9 unknown codes
    issue(4'h3, 4'd1, 4'd1, 4'd1);
    chk(!busy && !dio_oe && !ana_en, "R9 other code", busy, 0);
    issue(4'hF, 4'd1, 4'd1, 4'd1);
    chk(!busy && reg_sel == 4'd5, "R9 other code", reg_sel, 5);

    // read at tick every cycle, all pointers of interest
    tick_div = 1;
    for (int p = 0; p < 16; p += 5) begin
      issue(4'h9, 4'(p), 4'd0, 4'd0);
      wait_idle();
    end

    // R6 R7 windows
    tick_div = 2;
    for (int t = 0; t < 4; t++) begin
      issue(4'hA, 4'd0, 4'(t + 3), 4'(t));
      chk(ana_en && !dio_oe && ana_sel == 4'(t + 3), "R6 open", ana_sel, t + 3);
      wait_idle();
    end
    tick_div = 1;
    issue(4'hA, 4'd0, 4'd12, 4'd15);
    wait_idle();
    chk(!ana_en, "R7 long window closed", ana_en, 0);

    // command coinciding with a tick while idle
    tick_div = 4;
    do begin @(negedge clk); #1; end while (!tick_i);
    issue(4'h9, 4'd9, 4'd0, 4'd0);
    // command coinciding with the stop-bit tick
    do begin @(negedge clk); #1; end while (!(m_mode == 2 && m_idx == 9 && tick_i));
    issue(4'h9, 4'd3, 4'd0, 4'd0);
    @(negedge clk); #1;
    chk(!busy && reg_sel == 4'd9, "R8 stop-tick ignore", reg_sel, 9);
    issue(4'h9, 4'd3, 4'd0, 4'd0);
    chk(busy && reg_sel == 4'd3, "R5 accepts again", reg_sel, 3);
    wait_idle();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule